// File: doc/BRIEF.md
# Claim-Complete Platform Interrupt Controller

This block collects level-sensitive interrupt requests from up to 31 peripheral sources and steers them to a small set of processor contexts, sized here at two. Each source has a 3-bit priority. Each context has its own enable mask over the sources and a 3-bit threshold. A context's interrupt line is raised when at least one source is pending, enabled for that context, and has a priority strictly above that context's threshold.

Software handles an interrupt in two steps through a per-context claim register. A read of the register returns the identifier of the best eligible source and clears that source's pending bit in the same cycle. The source then stays blocked until software writes the same identifier back to the register. Source identifier 0 is reserved, and a claim that returns 0 means nothing is eligible. All registers are reached over a simple single-cycle read/write bus. Read data appears in the cycle after the request.

Top module: `irq_router`

## Requirements
- R1: Source 0 never becomes pending, and a claim read returns 0 when no enabled pending source has priority above the context's threshold. After reset every register reads 0 and both interrupt outputs are low.
- R2: The priority of source N sits at byte address 4*N. Only bits [2:0] are stored and the upper bits read 0. The priority of source 0 always reads 0.
- R3: The enable mask of context C is the 32-bit word at address 0x2000 + 0x80*C, and bit N enables source N. Bit 0 always reads 0.
- R4: The threshold of context C is at address 0x200000 + 0x1000*C, holds 3 bits and reads 0 in its upper bits. The claim/complete register of context C is at that address + 4.
- R5: A context's interrupt output is high exactly when some pending source enabled for it has priority strictly greater than its threshold. A threshold of 7 masks every source, and a priority of 0 never interrupts and is never claimed.
- R6: A claim read returns the eligible source with the highest priority. Among equal priorities it returns the lowest ID. The read clears that source's pending bit.
- R7: A claimed source cannot become pending again until its ID is written to a claim/complete register. If its request is still high after that write, it becomes pending again.
- R8: A completion write whose ID is not currently claimed (including 0) has no effect.
- R9: The interrupt outputs are registered. They rise two clock edges after a source request rises and respond one edge after a register write that changes eligibility.
- R10: Read data for a request is presented on the read-data port after the clock edge that accepts the request. A pending source stays latched even if its request drops before it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Level interrupt requests, bit N from source N (bit 0 unused) |
| bus_req | input | 1 | Register access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the accepting edge |
| ctx_irq | output | 2 | Interrupt line per context |

## Verification
Wrong internal state shows up at the ports in one of two ways. A pending or claimed bit that is stuck or lost makes a claim read return the wrong ID, or a non-zero ID where 0 is expected, on the very next read of the claim register. A wrong priority, enable or threshold value moves the interrupt line, and the registered output shows the error one edge after the state goes wrong. The bench sweeps every source, every priority against every threshold, and a full arbitration drain with ties. It also probes completions that should be ignored and confirms each by a claim read that follows.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTL_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTL_STRIDE = 32'h0000_1000;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRIO,
        RK_EN,
        RK_THR,
        RK_CLAIM
    } reg_kind_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int NUM_SRC = 32,
    parameter int IDW     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               claim_vld,
    input  logic [IDW-1:0]     claim_id,
    input  logic               cmpl_vld,
    input  logic [IDW-1:0]     cmpl_id,
    output logic [NUM_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] busy;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (claim_vld && claim_id == IDW'(s)) begin
                st_d.pend[s] = 1'b0;
                st_d.busy[s] = 1'b1;
            end
            if (cmpl_vld && cmpl_id == IDW'(s) && st_q.busy[s])
                st_d.busy[s] = 1'b0;
            if (src_req[s] && !st_q.pend[s] && !st_q.busy[s])
                st_d.pend[s] = 1'b1;
        end
        st_d.pend[0] = 1'b0;
        st_d.busy[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R7
    pend_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & st_q.busy) == '0);

    // R7
    claim_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vld |=> st_q.busy[$past(claim_id)]);

    // R8
    stray_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_vld && !st_q.busy[cmpl_id] && !claim_vld) |=> $stable(st_q.busy));

    // R1
    no_src0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend[0] && !st_q.busy[0]);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int IDW     = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             en,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thr,
    output logic [IDW-1:0]                 best_id,
    output logic                           best_vld
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_id  = '0;
        best_p   = '0;
        best_vld = 1'b0;
        for (int s = 1; s < NUM_SRC; s++) begin
            if (pend[s] && en[s] && prio[s] > thr && prio[s] > best_p) begin
                best_p   = prio[s];
                best_id  = IDW'(s);
                best_vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] ctx_irq
);
    localparam int IDW    = $clog2(NUM_SRC);
    localparam int EN_WDS = (NUM_SRC + 31) / 32;

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_CTX-1:0][NUM_SRC-1:0] en;
        logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
        logic [NUM_CTX-1:0]              irq;
        logic [31:0]                     rdata;
    } rt_st_t;

    rt_st_t st_d, st_q;

    logic [NUM_SRC-1:0]            pend;
    logic [NUM_CTX-1:0][IDW-1:0]   best_id;
    logic [NUM_CTX-1:0]            best_vld;
    logic                          claim_vld, cmpl_vld;
    logic [IDW-1:0]                claim_id, cmpl_id;

    logic [31:0] a32, en_off, ctl_off, dec_ctx, dec_idx;
    reg_kind_e   kind;

    // Address decode
    always_comb begin
        a32     = 32'(bus_addr);
        en_off  = a32 - EN_BASE;
        ctl_off = a32 - CTL_BASE;
        kind    = RK_NONE;
        dec_ctx = '0;
        dec_idx = '0;
        if (a32 < EN_BASE) begin
            kind    = RK_PRIO;
            dec_idx = (a32 - PRIO_BASE) >> 2;
        end else if (en_off < EN_STRIDE * 32'(NUM_CTX)) begin
            kind    = RK_EN;
            dec_ctx = en_off >> 7;
            dec_idx = 32'(en_off[6:2]);
        end else if (a32 >= CTL_BASE && ctl_off < CTL_STRIDE * 32'(NUM_CTX)) begin
            dec_ctx = ctl_off >> 12;
            if (ctl_off[11:0] == 12'h000) kind = RK_THR;
            else if (ctl_off[11:0] == 12'h004) kind = RK_CLAIM;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_pick (
                .pend    (pend),
                .en      (st_q.en[c]),
                .prio    (st_q.prio),
                .thr     (st_q.thr[c]),
                .best_id (best_id[c]),
                .best_vld(best_vld[c])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        claim_vld = 1'b0;
        claim_id  = '0;
        cmpl_vld  = 1'b0;
        cmpl_id   = bus_wdata[IDW-1:0];
        for (int c = 0; c < NUM_CTX; c++)
            st_d.irq[c] = best_vld[c];
        if (bus_req) begin
            if (!bus_we) st_d.rdata = '0;
            case (kind)
                RK_PRIO: begin
                    for (int s = 1; s < NUM_SRC; s++) begin
                        if (dec_idx == 32'(s)) begin
                            if (bus_we) st_d.prio[s] = bus_wdata[PRIO_W-1:0];
                            else        st_d.rdata   = 32'(st_q.prio[s]);
                        end
                    end
                end
                RK_EN: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        for (int w = 0; w < EN_WDS; w++) begin
                            if (dec_ctx == 32'(c) && dec_idx == 32'(w)) begin
                                for (int b = 0; b < 32; b++) begin
                                    if (w * 32 + b < NUM_SRC && w * 32 + b > 0) begin
                                        if (bus_we) st_d.en[c][w*32+b] = bus_wdata[b];
                                        else        st_d.rdata[b]      = st_q.en[c][w*32+b];
                                    end
                                end
                            end
                        end
                    end
                end
                RK_THR: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        if (dec_ctx == 32'(c)) begin
                            if (bus_we) st_d.thr[c] = bus_wdata[PRIO_W-1:0];
                            else        st_d.rdata  = 32'(st_q.thr[c]);
                        end
                    end
                end
                RK_CLAIM: begin
                    for (int c = 0; c < NUM_CTX; c++) begin
                        if (dec_ctx == 32'(c)) begin
                            if (bus_we) begin
                                cmpl_vld = (bus_wdata >> IDW) == '0;
                            end else begin
                                claim_vld  = best_vld[c];
                                claim_id   = best_id[c];
                                st_d.rdata = best_vld[c] ? 32'(best_id[c]) : '0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    irq_gate #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .claim_vld(claim_vld),
        .claim_id (claim_id),
        .cmpl_vld (cmpl_vld),
        .cmpl_id  (cmpl_id),
        .pend_o   (pend)
    );

    assign bus_rdata = st_q.rdata;
    assign ctx_irq   = st_q.irq;

    // R5
    thr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.thr[0] == 3'd7 |=> !ctx_irq[0]);

    // R2
    prio0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prio[0] == '0);

    // R6
    claim_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vld |-> pend[claim_id]);
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] src_req = '0;
    logic        bus_req = 0, bus_we = 0;
    logic [21:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ctx_irq;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
    );

    function automatic logic [21:0] a_prio(int s); return 22'(4 * s); endfunction
    function automatic logic [21:0] a_en(int c);   return 22'(32'h2000 + 32'h80 * c); endfunction
    function automatic logic [21:0] a_thr(int c);  return 22'(32'h200000 + 32'h1000 * c); endfunction
    function automatic logic [21:0] a_clm(int c);  return 22'(32'h200004 + 32'h1000 * c); endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [21:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [21:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] taken;
        idle(3);
        rst_n = 1;
        idle(1);

        // R1: reset state
        chk(ctx_irq == 2'b00, "R1 reset irq", int'(ctx_irq), 0);
        rd(a_clm(0), d); chk(d == 0, "R1 reset claim0", int'(d), 0);
        rd(a_thr(1), d); chk(d == 0, "R4 reset thr1", int'(d), 0);

        // R2: priority width and source 0
        wr(a_prio(5), 32'hFFFF_FFFD); rd(a_prio(5), d);
        chk(d == 5, "R2 prio mask", int'(d), 5);
        wr(a_prio(0), 32'h7); rd(a_prio(0), d);
        chk(d == 0, "R2 prio0", int'(d), 0);
        // R3: enable bit 0 reads 0
        wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), d);
        chk(d == 32'hFFFF_FFFE, "R3 en bit0", int'(d), int'(32'hFFFF_FFFE));
        wr(a_en(1), 32'h0);
        // R4: threshold width
        wr(a_thr(1), 32'hFE); rd(a_thr(1), d);
        chk(d == 6, "R4 thr mask", int'(d), 6);
        wr(a_thr(1), 0);

        // R9 exact latency, then per-source sweep for R6/R7
        wr(a_en(0), 32'hFFFF_FFFE);
        for (int s = 1; s < 32; s++) begin
            wr(a_prio(s), 32'((s % 7) + 1));
        end
        for (int s = 1; s < 32; s++) begin
            @(negedge clk); src_req[s] = 1;
            @(negedge clk);
            chk(ctx_irq[0] == 0, "R9 irq not yet", int'(ctx_irq[0]), 0);
            @(negedge clk);
            chk(ctx_irq == 2'b01, "R9 irq two edges", int'(ctx_irq), 1);
            rd(a_clm(1), d); chk(d == 0, "R3 ctx1 not enabled", int'(d), 0);
            rd(a_clm(0), d); chk(d == 32'(s), "R6 claim id", int'(d), s);
            rd(a_clm(0), d); chk(d == 0, "R7 blocked", int'(d), 0);
            chk(ctx_irq[0] == 0, "R5 irq drops", int'(ctx_irq[0]), 0);
            wr(a_clm(0), 32'(s)); idle(1);
            rd(a_clm(0), d); chk(d == 32'(s), "R7 repend", int'(d), s);
            src_req[s] = 0;
            wr(a_clm(0), 32'(s)); idle(1);
            rd(a_clm(0), d); chk(d == 0, "R7 clean", int'(d), 0);
        end

        // R5: priority vs threshold sweep, source 3 held pending
        src_req[3] = 1; idle(2); src_req[3] = 0;
        // R10: pending stays latched after request drops
        for (int p = 0; p < 8; p++) begin
            wr(a_prio(3), 32'(p));
            for (int t = 0; t < 8; t++) begin
                wr(a_thr(0), 32'(t));
                @(negedge clk);
                chk(ctx_irq[0] == (p > t), "R5 prio/thr", int'(ctx_irq[0]), int'(p > t));
            end
        end
        wr(a_thr(0), 0); wr(a_prio(3), 1);
        rd(a_clm(0), d); chk(d == 3, "R10 latched pend", int'(d), 3);
        wr(a_clm(0), 3);

        // R8: stray completions ignored
        src_req[9] = 1; idle(2);
        rd(a_clm(0), d); chk(d == 9, "R8 claim", int'(d), 9);
        wr(a_clm(0), 12); wr(a_clm(0), 0); wr(a_clm(0), 32'h29); idle(1);
        rd(a_clm(0), d); chk(d == 0, "R8 stray ignored", int'(d), 0);
        wr(a_clm(0), 9); idle(1);
        rd(a_clm(0), d); chk(d == 9, "R7 after real cmpl", int'(d), 9);
        src_req[9] = 0; wr(a_clm(0), 9);

        // R3/R4: context 1 routing
        wr(a_en(0), 0); wr(a_en(1), 32'h1 << 20);
        src_req[20] = 1; idle(3);
        chk(ctx_irq == 2'b10, "R3 ctx1 only", int'(ctx_irq), 2);
        rd(a_clm(0), d); chk(d == 0, "R3 ctx0 claim", int'(d), 0);
        rd(a_clm(1), d); chk(d == 20, "R4 ctx1 claim", int'(d), 20);
        src_req[20] = 0; wr(a_clm(1), 20); wr(a_en(1), 0);

        // R6/R5: arbitration drain with ties and zero priorities
        wr(a_en(0), 32'hFFFF_FFFE);
        for (int s = 1; s < 32; s++) wr(a_prio(s), 32'((s * 5) % 8));
        src_req = 32'hFFFF_FFFF; idle(3);
        taken = '0;
        for (int k = 0; k < 32; k++) begin
            int bi, bp;
            bi = 0; bp = 0;
            for (int s = 1; s < 32; s++)
                if (!taken[s] && ((s * 5) % 8) > bp) begin bp = (s * 5) % 8; bi = s; end
            rd(a_clm(0), d);
            chk(d == 32'(bi), "R6 arbitration order", int'(d), bi);
            if (bi != 0) taken[bi] = 1;
        end
        src_req = '0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule